// File: doc/BRIEF.md
# Regional Data Packet Router

This block sits at the link input of an off-detector readout driver. It inspects every 10-bit word arriving from one stave link and sends it to one of two destinations. Regional-data packets go to a track-finder port. Event-data packets go to the normal event-processing port. Idle words are discarded.

Regional payloads leave in tagged groups. Ahead of the first payload of each group the block sends one tag word, built from the link number and the crossing number that are present when that payload is taken. This lets several links share one track-finder output. A group ends when an event-data packet is accepted or when the group holds its maximum number of payload bytes. The next regional payload then opens a new group with a fresh tag.

All three data interfaces are valid/ready. A word moves when valid and ready are both high at a rising edge. A source must hold its valid and data stable until the word is taken.

The input ready depends on the kind of word offered:
- It is always high for an idle word.
- For a regional packet, it is high only when the track-finder path can take the packet.
- For an event packet, it is high only when the event buffer has room.

When the track-finder port stalls, only regional packets are held back. Event packets keep flowing into a two-entry buffer ahead of the event port, and that buffer drains independently.

Top module: `rd_packet_router`

## Requirements
- R1: After reset, `tf_valid` and `ev_valid` are both low.
- R2: Word fields are: bit 9 is the start bit, bit 8 is the type bit, and bits 7:0 are the payload byte. A valid word with bit 9 low is idle: `in_ready` is high for it, and it produces no output on either port.
- R3: An accepted word with bit 9 high and bit 8 low (event data) appears on `ev_data` as its byte. Event bytes leave in arrival order.
- R4: An accepted word with bits 9 and 8 both high (regional data) appears only on the track-finder port, as a payload word: `tf_tag` is 0 and `tf_data` is the byte zero-extended. Regional bytes leave in arrival order.
- R5: Before the first payload of each group, exactly one tag word is sent. Its `tf_tag` is 1 and its `tf_data` is `{link_id, bcid}`, sampled in the cycle that payload's input word was accepted.
- R6: Accepting an event-data word closes the open regional group. The next regional payload is preceded by a new tag.
- R7: A group carries at most 16 payloads (`MAX_CHUNK`). The 17th consecutive regional payload is preceded by a new tag.
- R8: While `tf_valid` is high and `tf_ready` is low, `tf_valid`, `tf_tag` and `tf_data` hold their values.
- R9: While `tf_ready` is low, event-data words are still accepted and delivered on the event port.
- R10: The event buffer holds `EV_DEPTH` (2) words. With `ev_ready` low and two words buffered, `in_ready` is low for an event word. While `ev_ready` is low, `ev_valid` and `ev_data` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Link word valid |
| in_ready | output | 1 | Link word taken at this edge when valid |
| in_pkt | input | 10 | Link word: start bit, type bit, byte |
| link_id | input | LINK_W (8) | Number of this link, used in tags |
| bcid | input | BCID_W (12) | Current crossing number, used in tags |
| ev_valid | output | 1 | Event byte valid |
| ev_ready | input | 1 | Event processor accepts |
| ev_data | output | 8 | Event payload byte |
| tf_valid | output | 1 | Track-finder word valid |
| tf_ready | input | 1 | Track-finder output accepts |
| tf_tag | output | 1 | 1 when the word is a group tag |
| tf_data | output | LINK_W+BCID_W (20) | Tag `{link_id,bcid}` or zero-extended byte |

## Verification
The hardest state to reach from the ports is a regional packet that opens a group and needs two output words while the track-finder port is stalled and event packets are arriving behind it. Only in that state do the pending payload, the group-closing event and the full event buffer interact.

The stimulus reaches it in two ways:
- A directed sequence drops `tf_ready`, sends one regional packet, and then pushes event packets while the event port keeps draining.
- A long random phase toggles both ready inputs independently while mixing idle, event and regional words.

Separate directed runs of 17 regional packets, and of a regional–event–regional pattern, force each group-closing rule.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  localparam int PKT_W     = 10;
  localparam int BYTE_W    = 8;
  localparam int START_POS = 9;
  localparam int TYPE_POS  = 8;

  typedef enum logic [1:0] {
    KIND_IDLE     = 2'd0,
    KIND_EVENT    = 2'd1,
    KIND_REGIONAL = 2'd2
  } pkt_kind_e;
endpackage

// File: rtl/rdr_classify.sv
module rdr_classify
  import rdr_pkg::*;
(
  input  logic [PKT_W-1:0]  pkt,
  output pkt_kind_e         kind,
  output logic [BYTE_W-1:0] payload
);
  always_comb begin
    if (!pkt[START_POS])    kind = KIND_IDLE;
    else if (pkt[TYPE_POS]) kind = KIND_REGIONAL;
    else                    kind = KIND_EVENT;
  end

  assign payload = pkt[BYTE_W-1:0];
endmodule

// File: rtl/rdr_event_skid.sv
module rdr_event_skid #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          pop;

  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign pop       = out_valid && out_ready;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/rdr_chunker.sv
module rdr_chunker #(
  parameter int TAG_W     = 20,
  parameter int BYTE_W    = 8,
  parameter int MAX_CHUNK = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_push,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic              close_req,
  output logic              rd_can,
  output logic              tf_valid,
  input  logic              tf_ready,
  output logic              tf_tag,
  output logic [TAG_W-1:0]  tf_data
);
  localparam int CW = $clog2(MAX_CHUNK + 1);

  logic              out_free;
  logic              pend_valid;
  logic [BYTE_W-1:0] pend_byte;
  logic              in_group;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     cnt_nxt;

  assign out_free = !tf_valid || tf_ready;
  assign rd_can   = out_free && !pend_valid;
  assign cnt_nxt  = cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tf_valid   <= 1'b0;
      tf_tag     <= 1'b0;
      tf_data    <= '0;
      pend_valid <= 1'b0;
      pend_byte  <= '0;
      in_group   <= 1'b0;
      cnt        <= '0;
    end else begin
      if (tf_valid && tf_ready) tf_valid <= 1'b0;
      if (pend_valid && out_free) begin
        // second word of a group opening: the held payload
        tf_valid   <= 1'b1;
        tf_tag     <= 1'b0;
        tf_data    <= TAG_W'(pend_byte);
        pend_valid <= 1'b0;
        cnt        <= CW'(1);
        if (MAX_CHUNK == 1) in_group <= 1'b0;
      end else if (rd_push) begin
        if (!in_group) begin
          tf_valid   <= 1'b1;
          tf_tag     <= 1'b1;
          tf_data    <= tag_in;
          pend_valid <= 1'b1;
          pend_byte  <= rd_byte;
          in_group   <= 1'b1;
        end else begin
          tf_valid <= 1'b1;
          tf_tag   <= 1'b0;
          tf_data  <= TAG_W'(rd_byte);
          cnt      <= cnt_nxt;
          if (cnt_nxt == CW'(MAX_CHUNK)) in_group <= 1'b0;
        end
      end
      if (close_req) in_group <= 1'b0;
    end
  end
endmodule

// File: rtl/rd_packet_router.sv
module rd_packet_router
  import rdr_pkg::*;
#(
  parameter int LINK_W    = 8,
  parameter int BCID_W    = 12,
  parameter int MAX_CHUNK = 16,
  parameter int EV_DEPTH  = 2,
  localparam int TAG_W    = LINK_W + BCID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PKT_W-1:0]  in_pkt,
  input  logic [LINK_W-1:0] link_id,
  input  logic [BCID_W-1:0] bcid,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [BYTE_W-1:0] ev_data,
  output logic              tf_valid,
  input  logic              tf_ready,
  output logic              tf_tag,
  output logic [TAG_W-1:0]  tf_data
);
  pkt_kind_e         kind;
  logic [BYTE_W-1:0] payload;
  logic              ev_full, ev_push, rd_push, rd_can;

  rdr_classify u_cls (.pkt(in_pkt), .kind(kind), .payload(payload));

  always_comb begin
    case (kind)
      KIND_REGIONAL: in_ready = rd_can;
      KIND_EVENT:    in_ready = !ev_full;
      default:       in_ready = 1'b1;
    endcase
  end

  assign ev_push = in_valid && (kind == KIND_EVENT) && !ev_full;
  assign rd_push = in_valid && (kind == KIND_REGIONAL) && rd_can;

  rdr_event_skid #(.W(BYTE_W), .DEPTH(EV_DEPTH)) u_ev (
    .clk(clk), .rst_n(rst_n), .push(ev_push), .din(payload), .full(ev_full),
    .out_valid(ev_valid), .out_ready(ev_ready), .out_data(ev_data)
  );

  rdr_chunker #(.TAG_W(TAG_W), .BYTE_W(BYTE_W), .MAX_CHUNK(MAX_CHUNK)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_push(rd_push), .rd_byte(payload),
    .tag_in({link_id, bcid}), .close_req(ev_push), .rd_can(rd_can),
    .tf_valid(tf_valid), .tf_ready(tf_ready), .tf_tag(tf_tag), .tf_data(tf_data)
  );
endmodule

// File: rtl/rdr_checker.sv
module rdr_checker #(
  parameter int TAG_W     = 20,
  parameter int MAX_CHUNK = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [9:0]       in_pkt,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic [7:0]       ev_data,
  input logic             tf_valid,
  input logic             tf_ready,
  input logic             tf_tag,
  input logic [TAG_W-1:0] tf_data
);
  localparam int CW = $clog2(MAX_CHUNK + 1) + 1;

  logic          last_was_tag;
  logic [CW-1:0] pay_cnt;
  logic          tf_fire;

  assign tf_fire = tf_valid && tf_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_was_tag <= 1'b0;
      pay_cnt      <= '0;
    end else if (tf_fire) begin
      last_was_tag <= tf_tag;
      pay_cnt      <= tf_tag ? '0 : pay_cnt + CW'(1);
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!tf_valid && !ev_valid));

  assert_idle_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_pkt[9]) |-> in_ready);

  assert_tag_then_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_fire && tf_tag) |-> !last_was_tag);

  assert_chunk_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_fire && !tf_tag) |-> (pay_cnt < CW'(MAX_CHUNK)));

  assert_tf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_valid && !tf_ready) |=> (tf_valid && $stable(tf_tag) && $stable(tf_data)));

  assert_ev_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_data)));
endmodule

bind rd_packet_router rdr_checker #(.TAG_W(TAG_W), .MAX_CHUNK(MAX_CHUNK)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_pkt(in_pkt), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_data(ev_data),
  .tf_valid(tf_valid), .tf_ready(tf_ready), .tf_tag(tf_tag), .tf_data(tf_data)
);

// File: tb/sim_rd_packet_router.sv
`timescale 1ns/1ps
module sim_rd_packet_router;
  localparam int T     = 20;
  localparam int CHUNK = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [9:0]  in_pkt = '0;
  logic [7:0]  link_id = 8'h5A;
  logic [11:0] bcid = '0;
  logic        ev_valid, ev_ready;
  logic [7:0]  ev_data;
  logic        tf_valid, tf_ready, tf_tag;
  logic [19:0] tf_data;

  rd_packet_router u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pkt(in_pkt), .link_id(link_id), .bcid(bcid),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_data(ev_data),
    .tf_valid(tf_valid), .tf_ready(tf_ready), .tf_tag(tf_tag), .tf_data(tf_data)
  );

  always #(T/2) clk = ~clk;
  always @(posedge clk) bcid <= bcid + 12'd1;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  bit rnd_ready = 0;
  bit force_tf = 1, force_ev = 1;
  int tag_fires = 0, ev_fires = 0;

  logic [7:0]  exp_ev[$];
  logic [20:0] exp_tf[$];
  bit grp = 0;
  int gcnt = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tf_ready <= rnd_ready ? ($urandom % 10 < 7) : force_tf;
    ev_ready <= rnd_ready ? ($urandom % 10 < 7) : force_ev;
  end

  // monitor and reference model, sampled mid-low-phase
  bit          prev_tf_stall = 0, prev_ev_stall = 0;
  logic [20:0] prev_tf = '0;
  logic [7:0]  prev_ev = '0;
  initial begin
    forever begin
      @(negedge clk); #5;
      if (rst_n) begin
        if (in_valid && !in_pkt[9]) check(in_ready, "R2 idle ready", in_ready, 1);
        if (in_valid && in_ready && in_pkt[9]) begin
          if (!in_pkt[8]) begin
            exp_ev.push_back(in_pkt[7:0]);
            grp = 0;                                   // R6 close
          end else begin
            if (!grp) begin
              exp_tf.push_back({1'b1, link_id, bcid}); // R5 tag
              grp = 1; gcnt = 0;
            end
            exp_tf.push_back({1'b0, 12'd0, in_pkt[7:0]});
            gcnt++;
            if (gcnt == CHUNK) grp = 0;                // R7 cap
          end
        end
        if (prev_tf_stall) check(tf_valid && {tf_tag, tf_data} == prev_tf, "R8 tf hold", {tf_tag, tf_data}, prev_tf);
        if (prev_ev_stall) check(ev_valid && ev_data == prev_ev, "R10 ev hold", ev_data, prev_ev);
        prev_tf_stall = tf_valid && !tf_ready; prev_tf = {tf_tag, tf_data};
        prev_ev_stall = ev_valid && !ev_ready; prev_ev = ev_data;
        if (ev_valid && ev_ready) begin
          ev_fires++;
          if (exp_ev.size() == 0) check(0, "R3 unexpected event byte", ev_data, 0);
          else begin
            logic [7:0] e;
            e = exp_ev.pop_front();
            check(ev_data == e, "R3 event byte", ev_data, e);
          end
        end
        if (tf_valid && tf_ready) begin
          if (tf_tag) tag_fires++;
          if (exp_tf.size() == 0) check(0, "R4 unexpected tf word", {tf_tag, tf_data}, 0);
          else begin
            logic [20:0] e;
            e = exp_tf.pop_front();
            check({tf_tag, tf_data} == e, e[20] ? "R5 tag word" : "R4 payload", {tf_tag, tf_data}, e);
          end
        end
      end
    end
  end

  // called at a negedge; returns at the negedge after acceptance
  task automatic send(input logic [9:0] p);
    bit ok;
    in_valid = 1'b1; in_pkt = p;
    forever begin
      #5 ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 1'b0;
  endtask

  function automatic logic [9:0] mk(input bit s, input bit t, input logic [7:0] b);
    return {s, t, b};
  endfunction

  task automatic drain();
    repeat (60) @(negedge clk);
  endtask

  initial begin
    int t0, e0;
    bit ok;
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    check(!tf_valid && !ev_valid, "R1 reset outputs", {tf_valid, ev_valid}, 0);
    @(negedge clk);

    // R7: 17 regional packets in a row -> two tags
    t0 = tag_fires;
    for (int i = 0; i < 17; i++) send(mk(1, 1, 8'(i)));
    drain();
    check(tag_fires - t0 == 2, "R7 tags for 17 payloads", tag_fires - t0, 2);

    // R6: regional, regional, event, regional -> two tags
    send(mk(1, 0, 8'hE0)); drain();
    t0 = tag_fires;
    send(mk(1, 1, 8'hA1)); send(mk(1, 1, 8'hA2));
    send(mk(1, 0, 8'hE1)); send(mk(1, 1, 8'hA3));
    drain();
    check(tag_fires - t0 == 2, "R6 event closes group", tag_fires - t0, 2);

    // R2: idle words produce nothing
    e0 = ev_fires; t0 = tag_fires;
    for (int i = 0; i < 5; i++) send(mk(0, i[0], 8'hFF));
    drain();
    check(ev_fires == e0 && tag_fires == t0, "R2 idle dropped", ev_fires - e0, 0);

    // R9: track-finder stalled, events still flow
    send(mk(1, 0, 8'hE2)); drain();
    force_tf = 0; @(negedge clk);
    e0 = ev_fires;
    send(mk(1, 1, 8'hB0));
    send(mk(1, 0, 8'hE3)); send(mk(1, 0, 8'hE4));
    repeat (5) @(negedge clk);
    check(ev_fires - e0 == 2, "R9 events pass stalled tf", ev_fires - e0, 2);
    check(tf_valid == 1'b1, "R9 tf word waiting", tf_valid, 1);
    force_tf = 1; drain();

    // R10: event buffer depth 2
    force_ev = 0; @(negedge clk);
    send(mk(1, 0, 8'hC0)); send(mk(1, 0, 8'hC1));
    in_valid = 1'b1; in_pkt = mk(1, 0, 8'hC2);
    #5 ok = in_ready;
    check(ok == 1'b0, "R10 full buffer back-pressure", ok, 0);
    @(negedge clk);
    force_ev = 1;
    send(mk(1, 0, 8'hC2));
    drain();

    // random phase
    rnd_ready = 1;
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 20;
      if (n % 500 == 0) link_id = 8'($urandom);
      if (r < 2)       send(mk(0, 1'($urandom), 8'($urandom)));
      else if (r < 11) send(mk(1, 0, 8'($urandom)));
      else             send(mk(1, 1, 8'($urandom)));
      if ($urandom % 8 == 0) @(negedge clk);
    end
    rnd_ready = 0; force_tf = 1; force_ev = 1;
    drain();
    check(exp_ev.size() == 0, "R3 all event bytes delivered", exp_ev.size(), 0);
    check(exp_tf.size() == 0, "R4 all regional words delivered", exp_tf.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(T * 150000);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule